// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave on a three-wire serial bus. A load strobe frames each transaction, a bit clock carries it, and a single data line is split into an input, an output and an output enable. It holds five configuration registers of unequal length and drives their live values out as parallel words. Every wire of the serial bus is sampled by the fast system clock, so the register bank and the logic around it sit in one clock domain.

The frame starts with a five-bit header: a direction flag (0 writes, 1 reads), a test bit, then a three-bit address sent least significant bit first. In a write, the data for the addressed register follows, least significant bit first. If the load strobe stays low, the data for the next higher address comes straight after it. Each register takes in exactly its own number of bits. Completed registers are held in staging storage, and all of them take effect together when the load strobe rises. In a read, the block drives the addressed register onto the data line, starting at the fifth falling edge of the bit clock. After a reset, writes are refused for a set number of clock cycles while the calibration runs.

Top module: `serial_cfg_port`

## Requirements
- R1: The header bits are taken on bit-clock rising edges while the strobe is low. They arrive in this order: direction flag (0 = write), test bit, address bit 0, address bit 1, address bit 2. Data bits follow, starting at bit 0.
- R2: The address selects a register and fixes its length: 0 is the 11-bit operation word, 1 the 10-bit gain word, 2 the 8-bit clamp word, 3 the 10-bit control word and 4 the 6-bit front gain word.
- R3: After reset the outputs hold operation 0x000, gain 0x096, clamp 0x080, control 0x000 and front gain 0x00.
- R4: When the strobe stays low after one register is complete, the following bits fill the next higher address. Bits aimed at addresses 5 to 7 change nothing.
- R5: No register output changes while a frame is in progress. All registers completed in a write frame update together after the strobe rises.
- R6: If the strobe rises before a register has received all its bits, that register is left unchanged. Registers completed earlier in the same frame still update.
- R7: In a read frame, the output enable rises after the fifth falling bit-clock edge and carries bit 0. Each following falling edge moves on one bit. Positions past the register length read as 0, and the enable drops when the strobe rises.
- R8: A committed operation word with bit 4 set returns all five registers to their reset values, including the operation word itself.
- R9: For LOCK_CYCLES clock cycles after reset, a write frame changes no register.
- R10: A write frame whose test bit is 1 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial bus |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sl | input | 1 | Load strobe, low during a frame |
| sck | input | 1 | Serial bit clock |
| sdata_in | input | 1 | Serial data from the host |
| sdata_out | output | 1 | Serial data to the host during a read |
| sdata_oe | output | 1 | Enable for the serial data driver |
| cfg_oper | output | 11 | Operation word (address 0) |
| cfg_gain | output | 10 | Gain word (address 1) |
| cfg_clamp | output | 8 | Clamp word (address 2) |
| cfg_ctrl | output | 10 | Control word (address 3) |
| cfg_fgain | output | 6 | Front gain word (address 4) |

## Verification
The assertions rely on the strobe and the bit clock never changing in the same sampled clock cycle. They also rely on the data line being stable for at least two system clocks before each rising bit-clock edge, because the edge detector has to place every bit correctly against the frame. The bench keeps each bit-clock half period at six system clocks. It changes data only while the bit clock is low and keeps a half period of space between the strobe and the nearest bit-clock edge, so these conditions always hold.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
   localparam int NUM_REGS  = 5;
   localparam int MAX_LEN   = 11;
   localparam int ADDR_W    = 3;
   localparam int IDX_W     = $clog2(MAX_LEN);
   localparam int LEN_W     = IDX_W + 1;
   localparam int RESET_BIT = 4;

   typedef logic [MAX_LEN-1:0] word_t;
   typedef logic [NUM_REGS-1:0][MAX_LEN-1:0] bank_t;

   function automatic logic [LEN_W-1:0] reg_len(input logic [ADDR_W-1:0] a);
      case (a)
         3'd0:    reg_len = LEN_W'(11);
         3'd1:    reg_len = LEN_W'(10);
         3'd2:    reg_len = LEN_W'(8);
         3'd3:    reg_len = LEN_W'(10);
         3'd4:    reg_len = LEN_W'(6);
         default: reg_len = '0;
      endcase
   endfunction

   function automatic word_t reg_default(input logic [ADDR_W-1:0] a);
      case (a)
         3'd1:    reg_default = word_t'(11'h096);
         3'd2:    reg_default = word_t'(11'h080);
         default: reg_default = '0;
      endcase
   endfunction
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
   parameter int          W      = 3,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] INIT  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] q,
   output logic [W-1:0] q_d
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("scfg_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s <= STAGES; s++) pipe[s] <= INIT;
      end else begin
         pipe[0] <= din;
         for (int s = 1; s <= STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign q   = pipe[STAGES-1];
   assign q_d = pipe[STAGES];
endmodule

// File: rtl/scfg_frame.sv
module scfg_frame
   import scfg_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sl_lvl,
   input  logic                sl_fall,
   input  logic                sl_rise,
   input  logic                sck_rise,
   input  logic                sck_fall,
   input  logic                sdi,
   input  bank_t               live,
   output bank_t               stage,
   output logic [NUM_REGS-1:0] staged,
   output logic                commit,
   output logic                sdo,
   output logic                sdo_en
);
   logic [2:0]        hcnt;
   logic              hdr_done, rnw, tbit;
   logic [ADDR_W-1:0] addr;
   logic [IDX_W-1:0]  idx, ridx;
   logic [2:0]        fcnt;
   word_t             shreg, shnext;
   logic              writing, last_bit;

   function automatic logic read_bit(input bank_t b, input logic [ADDR_W-1:0] a,
                                     input logic [IDX_W-1:0] i);
      if (a < ADDR_W'(NUM_REGS) && {1'b0, i} < reg_len(a)) read_bit = b[a][i];
      else                                                  read_bit = 1'b0;
   endfunction

   always_comb begin
      shnext      = shreg;
      shnext[idx] = sdi;
   end

   assign writing  = hdr_done && !rnw && (addr < ADDR_W'(NUM_REGS));
   assign last_bit = ({1'b0, idx} + LEN_W'(1)) == reg_len(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0; hdr_done <= 1'b0; rnw <= 1'b0; tbit <= 1'b0;
         addr <= '0; idx <= '0; ridx <= '0; fcnt <= '0; shreg <= '0;
         stage <= '0; staged <= '0; commit <= 1'b0; sdo <= 1'b0; sdo_en <= 1'b0;
      end else begin
         commit <= 1'b0;
         if (sl_fall) begin
            hcnt <= '0; hdr_done <= 1'b0; rnw <= 1'b0; tbit <= 1'b0;
            addr <= '0; idx <= '0; fcnt <= '0; shreg <= '0;
            staged <= '0; sdo <= 1'b0; sdo_en <= 1'b0;
         end else if (sl_rise) begin
            commit <= hdr_done && !rnw && !tbit;
            sdo    <= 1'b0;
            sdo_en <= 1'b0;
         end else if (!sl_lvl) begin
            if (sck_rise) begin
               if (!hdr_done) begin
                  case (hcnt)
                     3'd0:    rnw     <= sdi;
                     3'd1:    tbit    <= sdi;
                     3'd2:    addr[0] <= sdi;
                     3'd3:    addr[1] <= sdi;
                     default: addr[2] <= sdi;
                  endcase
                  hcnt <= hcnt + 3'd1;
                  if (hcnt == 3'd4) hdr_done <= 1'b1;
               end else if (writing) begin
                  if (last_bit) begin
                     stage[addr]  <= shnext;
                     staged[addr] <= 1'b1;
                     addr         <= addr + ADDR_W'(1);
                     idx          <= '0;
                     shreg        <= '0;
                  end else begin
                     shreg <= shnext;
                     idx   <= idx + IDX_W'(1);
                  end
               end
            end
            if (sck_fall) begin
               if (fcnt != 3'd5) fcnt <= fcnt + 3'd1;
               if (fcnt == 3'd4 && hdr_done && rnw) begin
                  sdo_en <= 1'b1;
                  sdo    <= read_bit(live, addr, '0);
                  ridx   <= IDX_W'(1);
               end else if (sdo_en) begin
                  sdo <= read_bit(live, addr, ridx);
                  if (ridx != '1) ridx <= ridx + IDX_W'(1);
               end
            end
         end
      end
   end
endmodule

// File: rtl/scfg_regbank.sv
module scfg_regbank
   import scfg_pkg::*;
#(
   parameter int LOCK_CYCLES = 250000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                commit,
   input  logic [NUM_REGS-1:0] staged,
   input  bank_t               stage,
   output bank_t               live
);
   localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LOCK_CYCLES);

   generate
      if (LOCK_CYCLES < 1) begin : g_bad
         $error("scfg_regbank needs LOCK_CYCLES of at least one");
      end
   endgenerate

   logic [CNT_W-1:0] lock_cnt;
   logic             locked, apply, wipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 lock_cnt <= '0;
      else if (lock_cnt != CNT_END) lock_cnt <= lock_cnt + CNT_W'(1);
   end

   assign locked = (lock_cnt != CNT_END);
   assign apply  = commit && !locked;
   assign wipe   = staged[0] && stage[0][RESET_BIT];

   word_t live_q [NUM_REGS];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                live_q[i] <= reg_default(ADDR_W'(i));
            else if (apply && wipe)    live_q[i] <= reg_default(ADDR_W'(i));
            else if (apply && staged[i]) live_q[i] <= stage[i];
         end
         assign live[i] = live_q[i];
      end
   endgenerate
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
   import scfg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_CYCLES = 250000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sl,
   input  logic        sck,
   input  logic        sdata_in,
   output logic        sdata_out,
   output logic        sdata_oe,
   output logic [10:0] cfg_oper,
   output logic [9:0]  cfg_gain,
   output logic [7:0]  cfg_clamp,
   output logic [9:0]  cfg_ctrl,
   output logic [5:0]  cfg_fgain
);
   logic [2:0]          bus_q, bus_d;
   logic                sl_lvl, sl_fall, sl_rise, sck_rise, sck_fall, sdi;
   logic                commit;
   logic [NUM_REGS-1:0] staged;
   bank_t               stage, live;

   scfg_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b001)) sync_i (
      .clk(clk), .rst_n(rst_n), .din({sdata_in, sck, sl}), .q(bus_q), .q_d(bus_d)
   );

   assign sl_lvl   = bus_q[0];
   assign sl_fall  = ~bus_q[0] &  bus_d[0];
   assign sl_rise  =  bus_q[0] & ~bus_d[0];
   assign sck_rise =  bus_q[1] & ~bus_d[1];
   assign sck_fall = ~bus_q[1] &  bus_d[1];
   assign sdi      =  bus_d[2] &  bus_q[2] | bus_d[2] & ~bus_q[2];

   scfg_frame frame_i (
      .clk(clk), .rst_n(rst_n), .sl_lvl(sl_lvl), .sl_fall(sl_fall), .sl_rise(sl_rise),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi(sdi), .live(live),
      .stage(stage), .staged(staged), .commit(commit), .sdo(sdata_out), .sdo_en(sdata_oe)
   );

   scfg_regbank #(.LOCK_CYCLES(LOCK_CYCLES)) bank_i (
      .clk(clk), .rst_n(rst_n), .commit(commit), .staged(staged), .stage(stage), .live(live)
   );

   assign cfg_oper  = live[0][10:0];
   assign cfg_gain  = live[1][9:0];
   assign cfg_clamp = live[2][7:0];
   assign cfg_ctrl  = live[3][9:0];
   assign cfg_fgain = live[4][5:0];
endmodule

// File: rtl/scfg_checker.sv
module scfg_checker
   import scfg_pkg::*;
#(
   parameter int LOCK_CYCLES = 250000
) (
   input logic                clk,
   input logic                rst_n,
   input logic                commit,
   input logic                sl_rise,
   input logic                sl_fall,
   input logic                sck_fall,
   input logic                sdata_out,
   input logic                sdata_oe,
   input logic [NUM_REGS-1:0] staged,
   input bank_t               stage,
   input bank_t               live
);
   localparam int CW = $clog2(LOCK_CYCLES + 2);
   logic [CW-1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         age <= '0;
      else if (age != CW'(LOCK_CYCLES + 1)) age <= age + CW'(1);
   end

   assert_quiet_midframe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(live));

   assert_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (age < CW'(LOCK_CYCLES)) |=> $stable(live));

   assert_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && age >= CW'(LOCK_CYCLES) && staged[0] && stage[0][4]) |=>
      (live[0] == '0 && live[1] == word_t'(11'h096) && live[2] == word_t'(11'h080)
       && live[3] == '0 && live[4] == '0));

   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sl_rise |=> !sdata_oe);

   assert_fall_paced_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sck_fall && !sl_rise && !sl_fall) |=> ($stable(sdata_out) && !$rose(sdata_oe)));
endmodule

bind serial_cfg_port scfg_checker #(.LOCK_CYCLES(LOCK_CYCLES)) chk_i (
   .clk(clk), .rst_n(rst_n), .commit(commit), .sl_rise(sl_rise), .sl_fall(sl_fall),
   .sck_fall(sck_fall), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
   .staged(staged), .stage(stage), .live(live)
);

// File: tb/serial_cfg_port_tb.sv
module serial_cfg_port_tb_top;
   localparam int HALF = 6;
   localparam int LOCK = 400;

   logic clk = 1'b0, rst_n = 1'b0, sl = 1'b1, sck = 1'b0, sdata_in = 1'b0;
   logic sdata_out, sdata_oe;
   logic [10:0] cfg_oper;
   logic [9:0]  cfg_gain, cfg_ctrl;
   logic [7:0]  cfg_clamp;
   logic [5:0]  cfg_fgain;
   int n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   serial_cfg_port #(.SYNC_STAGES(2), .LOCK_CYCLES(LOCK)) dut_i (
      .clk(clk), .rst_n(rst_n), .sl(sl), .sck(sck), .sdata_in(sdata_in),
      .sdata_out(sdata_out), .sdata_oe(sdata_oe), .cfg_oper(cfg_oper), .cfg_gain(cfg_gain),
      .cfg_clamp(cfg_clamp), .cfg_ctrl(cfg_ctrl), .cfg_fgain(cfg_fgain)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req, input logic [10:0] o, input logic [9:0] g,
                            input logic [7:0] c, input logic [9:0] t, input logic [5:0] f);
      check({req, " oper"},  16'(cfg_oper),  16'(o));
      check({req, " gain"},  16'(cfg_gain),  16'(g));
      check({req, " clamp"}, 16'(cfg_clamp), 16'(c));
      check({req, " ctrl"},  16'(cfg_ctrl),  16'(t));
      check({req, " fgain"}, 16'(cfg_fgain), 16'(f));
   endtask

   task automatic put_bit(input logic b);
      sdata_in = b;
      tick(HALF);
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
   endtask

   task automatic send(input logic [15:0] v, input int n);
      for (int i = 0; i < n; i++) put_bit(v[i]);
   endtask

   task automatic open_frame(input logic rd, input logic tst, input logic [2:0] a);
      sl = 1'b0;
      tick(HALF);
      put_bit(rd); put_bit(tst); put_bit(a[0]); put_bit(a[1]); put_bit(a[2]);
   endtask

   task automatic close_frame;
      tick(HALF);
      sl = 1'b1;
      tick(12);
   endtask

   // R9: a write inside the lockout window leaves the gain word alone
   task automatic t_lockout;
      open_frame(1'b0, 1'b0, 3'd1);
      send(16'h03FF, 10);
      close_frame();
      check("R9 gain during lockout", 16'(cfg_gain), 16'h096);
      tick(LOCK);
   endtask

   // R1 R2: one write to the gain word
   task automatic t_single;
      open_frame(1'b0, 1'b0, 3'd1);
      send(16'h02A5, 10);
      close_frame();
      check_all("R1 R2 single", 11'h000, 10'h2A5, 8'h80, 10'h000, 6'h00);
   endtask

   // R4 R5: gain, clamp and control in one frame
   task automatic t_burst;
      open_frame(1'b0, 1'b0, 3'd1);
      send(16'h0155, 10);
      send(16'h003C, 8);
      send(16'h0201, 10);
      tick(HALF);
      check_all("R5 before strobe", 11'h000, 10'h2A5, 8'h80, 10'h000, 6'h00);
      close_frame();
      check_all("R4 burst", 11'h000, 10'h155, 8'h3C, 10'h201, 6'h00);
   endtask

   // R4: control, front gain, then bits past the last address
   task automatic t_overrun;
      open_frame(1'b0, 1'b0, 3'd3);
      send(16'h00F0, 10);
      send(16'h002B, 6);
      send(16'h00FF, 8);
      close_frame();
      check_all("R4 overrun", 11'h000, 10'h155, 8'h3C, 10'h0F0, 6'h2B);
   endtask

   // R6: the clamp word completes, the control word is cut short
   task automatic t_partial;
      open_frame(1'b0, 1'b0, 3'd2);
      send(16'h00A7, 8);
      send(16'h000F, 4);
      close_frame();
      check_all("R6 partial", 11'h000, 10'h155, 8'hA7, 10'h0F0, 6'h2B);
   endtask

   // R10: test bit set
   task automatic t_testbit;
      open_frame(1'b0, 1'b1, 3'd4);
      send(16'h0015, 6);
      close_frame();
      check("R10 fgain kept", 16'(cfg_fgain), 16'h2B);
   endtask

   // R2: full 11-bit operation word with the reset bit clear
   task automatic t_oper;
      open_frame(1'b0, 1'b0, 3'd0);
      send(16'h040B, 11);
      close_frame();
      check("R2 oper", 16'(cfg_oper), 16'h40B);
   endtask

   // R7: read a register, 2 extra positions past its length
   task automatic t_read(input logic [2:0] a, input int len, input logic [15:0] exp);
      logic [15:0] got;
      got = '0;
      sl = 1'b0;
      tick(HALF);
      put_bit(1'b1); put_bit(1'b0); put_bit(a[0]); put_bit(a[1]);
      tick(5);
      check("R7 no drive before fifth fall", 16'(sdata_oe), 16'h0);
      put_bit(a[2]);
      tick(5);
      check("R7 drive after fifth fall", 16'(sdata_oe), 16'h1);
      got[0] = sdata_out;
      for (int i = 1; i < len + 2; i++) begin
         tick(1);
         sck = 1'b1;
         tick(HALF);
         sck = 1'b0;
         tick(5);
         got[i] = sdata_out;
      end
      check("R7 read value", got, exp);
      tick(1);
      sl = 1'b1;
      tick(12);
      check("R7 released", 16'(sdata_oe), 16'h0);
   endtask

   // R8: reset bit in the operation word
   task automatic t_wipe;
      open_frame(1'b0, 1'b0, 3'd0);
      send(16'h0013, 11);
      close_frame();
      check_all("R8 wipe", 11'h000, 10'h096, 8'h80, 10'h000, 6'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      check_all("R3 reset", 11'h000, 10'h096, 8'h80, 10'h000, 6'h00);
      t_lockout();
      t_single();
      t_burst();
      t_overrun();
      t_partial();
      t_testbit();
      t_oper();
      t_read(3'd1, 10, 16'h0155);
      t_read(3'd2, 8, 16'h00A7);
      t_read(3'd4, 6, 16'h002B);
      check_all("R7 read changes nothing", 11'h40B, 10'h155, 8'hA7, 10'h0F0, 6'h2B);
      t_wipe();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule